// File: doc/BRIEF.md
# Hard-Decision Bit-Flipping Parity Decoder

This block corrects one 8-bit received word of a short regular binary low-density parity-check code. The code is fixed by a 4x8 parity-check matrix in which every bit takes part in exactly two checks and every check covers exactly four bits. The word comes in on a valid/ready handshake. The block then runs hard-decision bit-flipping. In each pass it evaluates all four checks (the check-node step). For each bit it counts the failed checks that include that bit, and it inverts every bit whose count equals the largest count (the bit-node step).

Decoding ends in one of two ways. If every check holds, the word is declared good and four message bits are picked from parameter-selected positions. If the iteration budget runs out first, the block reports failure and presents the word as it stands at that point. The result is held on an output handshake until the downstream side takes it. No new word is accepted until the result has been handed over.

The checks, from bit 0 to bit 7, cover these bits: check A covers bits 1, 3, 4 and 7; check B covers bits 0, 1, 2 and 5; check C covers bits 2, 5, 6 and 7; check D covers bits 0, 3, 4 and 6. Bits 3 and 4 sit in the same pair of checks, and so do bits 2 and 5. Because of this, an error on one bit of such a pair cannot be told apart from an error on the other.

Top module: `ldpc_bf_dec`

## Requirements
- R1: `out_ok` is 1 only when each of the four checks A to D has even parity over `out_word`. Each check is the XOR of the bits listed for it above.
- R2: A word that passes all four checks when it is loaded is returned unchanged, with `out_iters` = 0 and `out_ok` = 1.
- R3: Each iteration first counts, for every bit, how many failed checks include that bit. It then flips every bit whose count equals the maximum over all bits, as long as that maximum is at least 1.
- R4: Iterations stop as soon as all checks pass. `out_iters` then equals the number of flip passes performed. A single error on bit 0, 1, 6 or 7 of a codeword is corrected in exactly one pass.
- R5: If the checks still fail after `MAX_ITER` passes (default 10), the block returns `out_ok` = 0 and `out_iters` = `MAX_ITER`. `out_word` is then the word after the last pass, with no further flip applied. Two examples: a single error on bit 3 of a codeword flips the pair of bits 3 and 4 on every pass, so it never resolves; and the all-failing word 0x81 also never resolves.
- R6: On success, `out_msg[i]` equals `out_word[MSG_POS[i]]`, with default positions 4, 5, 6 and 7 for i = 0 to 3. On failure, `out_msg` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word`, `out_msg`, `out_ok` and `out_iters` all hold their values.
- R8: `in_ready` is 0 from the moment a word is accepted until its result has been taken. A word presented during that time has no effect on the current result.
- R9: `out_iters` never exceeds `MAX_ITER`.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received word is present |
| in_ready | output | 1 | Decoder is idle and takes a word |
| in_word | input | 8 | Received hard-decision word |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_word | output | 8 | Decoded (or last) word |
| out_msg | output | 4 | Message bits, zero on failure |
| out_ok | output | 1 | All checks satisfied |
| out_iters | output | ITER_W (4) | Flip passes performed |

## Verification
On every cycle, the bound assertions check four things. A word flagged good satisfies all four checks. A failed result always carries the full iteration count and a zero message. The iteration count never passes its limit. A held result stays stable under back-pressure, and the input side stays closed while a result is pending. The flip rule itself can only be shown by the bench's scenarios. These compare each result with an independent model of the max-count flipping rule. That model covers clean codewords, correctable single errors, the indistinguishable bit pairs that oscillate until the budget runs out, double errors and the all-checks-failing word.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;
   localparam int N  = 8;
   localparam int M  = 4;
   localparam int K  = 4;
   localparam int PW = $clog2(N);
   localparam int CW = $clog2(M + 1);

   // Row r, bit c set when check r covers codeword bit c
   localparam logic [M-1:0][N-1:0] H_MAT = {8'h59, 8'hE4, 8'h27, 8'h9A};

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} dec_state_t;

   function automatic logic [M-1:0] check_vec(input logic [N-1:0] w);
      logic [M-1:0] s;
      for (int r = 0; r < M; r++) s[r] = ^(w & H_MAT[r]);
      return s;
   endfunction
endpackage

// File: rtl/ldpc_chk_nodes.sv
module ldpc_chk_nodes #(
   parameter int N = 8,
   parameter int M = 4,
   parameter logic [M-1:0][N-1:0] H = '0
) (
   input  logic [N-1:0] word,
   output logic [M-1:0] fail
);
   for (genvar r = 0; r < M; r++) begin : g_row
      assign fail[r] = ^(word & H[r]);
   end
endmodule

// File: rtl/ldpc_bit_nodes.sv
module ldpc_bit_nodes #(
   parameter int N = 8,
   parameter int M = 4,
   parameter logic [M-1:0][N-1:0] H = '0,
   localparam int CW = $clog2(M + 1)
) (
   input  logic [M-1:0] fail,
   output logic [N-1:0] flip
);
   logic [CW-1:0] votes [N];
   logic [CW-1:0] top;

   always_comb begin
      for (int b = 0; b < N; b++) begin
         votes[b] = '0;
         for (int r = 0; r < M; r++)
            votes[b] = votes[b] + CW'(fail[r] & H[r][b]);
      end
   end

   always_comb begin
      top = '0;
      for (int b = 0; b < N; b++)
         if (votes[b] > top) top = votes[b];
   end

   for (genvar b = 0; b < N; b++) begin : g_flip
      assign flip[b] = (top != '0) && (votes[b] == top);
   end
endmodule

// File: rtl/ldpc_msg_pick.sv
module ldpc_msg_pick #(
   parameter int N  = 8,
   parameter int K  = 4,
   parameter int PW = 3,
   parameter logic [K-1:0][PW-1:0] POS = '0
) (
   input  logic [N-1:0] word,
   input  logic         en,
   output logic [K-1:0] msg
);
   for (genvar i = 0; i < K; i++) begin : g_pick
      assign msg[i] = en & word[POS[i]];
   end
endmodule

// File: rtl/ldpc_bf_dec.sv
module ldpc_bf_dec
   import ldpc_bf_pkg::*;
#(
   parameter int MAX_ITER = 10,
   parameter logic [K-1:0][PW-1:0] MSG_POS = {3'd7, 3'd6, 3'd5, 3'd4},
   localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [N-1:0]      in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [N-1:0]      out_word,
   output logic [K-1:0]      out_msg,
   output logic              out_ok,
   output logic [ITER_W-1:0] out_iters
);
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("MAX_ITER must be at least 1");
   end
   for (genvar i = 0; i < K; i++) begin : g_pos_chk
      if (MSG_POS[i] >= N) begin : g_bad_pos
         $error("MSG_POS entry out of range");
      end
   end

   dec_state_t        state_q;
   logic [N-1:0]      word_q;
   logic [ITER_W-1:0] iter_q;
   logic              ok_q;
   logic [M-1:0]      fail_w;
   logic [N-1:0]      flip_w;

   ldpc_chk_nodes #(.N(N), .M(M), .H(H_MAT)) u_chk (
      .word (word_q),
      .fail (fail_w)
   );

   ldpc_bit_nodes #(.N(N), .M(M), .H(H_MAT)) u_bit (
      .fail (fail_w),
      .flip (flip_w)
   );

   ldpc_msg_pick #(.N(N), .K(K), .PW(PW), .POS(MSG_POS)) u_pick (
      .word (word_q),
      .en   (ok_q),
      .msg  (out_msg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         iter_q  <= '0;
         ok_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (in_valid) begin
               word_q  <= in_word;
               iter_q  <= '0;
               ok_q    <= 1'b0;
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (fail_w == '0) begin
                  ok_q    <= 1'b1;
                  state_q <= ST_DONE;
               end else if (iter_q == ITER_W'(MAX_ITER)) begin
                  ok_q    <= 1'b0;
                  state_q <= ST_DONE;
               end else begin
                  word_q <= word_q ^ flip_w;
                  iter_q <= iter_q + 1'b1;
               end
            end
            ST_DONE: if (out_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_DONE);
   assign out_word  = word_q;
   assign out_ok    = ok_q;
   assign out_iters = iter_q;
endmodule

// File: rtl/ldpc_bf_dec_chk.sv
module ldpc_bf_dec_chk
   import ldpc_bf_pkg::*;
#(
   parameter int MAX_ITER = 10,
   localparam int ITER_W = $clog2(MAX_ITER + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [N-1:0]      out_word,
   input logic [K-1:0]      out_msg,
   input logic              out_ok,
   input logic [ITER_W-1:0] out_iters
);
   // R1
   ok_means_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ok) |-> (check_vec(out_word) == '0));

   // R5
   fail_full_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ok) |-> (out_iters == ITER_W'(MAX_ITER)));

   // R6
   fail_msg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ok) |-> (out_msg == '0));

   // R7
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
         $stable(out_msg) && $stable(out_ok) && $stable(out_iters)));

   // R8
   busy_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R9
   iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_iters <= ITER_W'(MAX_ITER));
endmodule

bind ldpc_bf_dec ldpc_bf_dec_chk #(.MAX_ITER(MAX_ITER)) u_bf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .out_msg   (out_msg),
   .out_ok    (out_ok),
   .out_iters (out_iters)
);

// File: tb/ldpc_bf_dec_tb.sv
module ldpc_bf_dec_tb;
   localparam int LIMIT = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_word = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_word;
   logic [3:0] out_msg;
   logic       out_ok;
   logic [3:0] out_iters;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ldpc_bf_dec #(.MAX_ITER(LIMIT)) u_dut (
      .clk, .rst_n, .in_valid, .in_ready, .in_word,
      .out_valid, .out_ready, .out_word, .out_msg, .out_ok, .out_iters
   );

   // Check coverage per requirement text: A{1,3,4,7} B{0,1,2,5} C{2,5,6,7} D{0,3,4,6}
   localparam logic [7:0] CK [4] = '{8'h9A, 8'h27, 8'hE4, 8'h59};

   function automatic logic [3:0] syn(input logic [7:0] w);
      logic [3:0] s;
      for (int r = 0; r < 4; r++) s[r] = ^(w & CK[r]);
      return s;
   endfunction

   function automatic void model(input logic [7:0] w, output logic [7:0] o,
                                 output logic ok, output int it);
      int cnt [8];
      int mx;
      o = w; it = 0; ok = 0;
      forever begin
         logic [3:0] s;
         s = syn(o);
         if (s == 0) begin ok = 1; break; end
         if (it == LIMIT) break;
         mx = 0;
         for (int b = 0; b < 8; b++) begin
            cnt[b] = 0;
            for (int r = 0; r < 4; r++) if (s[r] && CK[r][b]) cnt[b]++;
            if (cnt[b] > mx) mx = cnt[b];
         end
         for (int b = 0; b < 8; b++) if (mx > 0 && cnt[b] == mx) o[b] = ~o[b];
         it++;
      end
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] w);
      @(negedge clk);
      in_valid = 1'b1; in_word = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_out();
      int n = 0;
      while (!out_valid && n < 200) begin @(negedge clk); n++; end
   endtask

   task automatic judge(input logic [7:0] w, input string req);
      logic [7:0] eo; logic eok; int eit;
      model(w, eo, eok, eit);
      chk(req, "out_valid", int'(out_valid), 1);
      chk(req, "out_word", int'(out_word), int'(eo));
      chk("R1", "out_ok", int'(out_ok), int'(eok));
      chk(req, "out_iters", int'(out_iters), eit);
      chk("R6", "out_msg", int'(out_msg), eok ? int'(eo[7:4]) : 0);
   endtask

   task automatic decode(input logic [7:0] w, input string req);
      send(w);
      wait_out();
      judge(w, req);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R10", "in_ready", int'(in_ready), 1);
      chk("R10", "out_valid", int'(out_valid), 0);
   endtask

   task automatic t_clean();
      decode(8'h00, "R2");
      decode(8'hC3, "R2");
      decode(8'h24, "R2");
      chk("R2", "iters clean", int'(out_iters), 0);
   endtask

   task automatic t_single();
      for (int b = 0; b < 8; b++) begin
         if (b == 2 || b == 3 || b == 4 || b == 5) continue;
         decode(8'hC3 ^ (8'h01 << b), "R4");
         chk("R4", "one pass", int'(out_iters), 1);
         chk("R3", "corrected", int'(out_word), 8'hC3);
      end
   endtask

   task automatic t_twin();
      decode(8'h08, "R5");
      chk("R5", "oscillated word", int'(out_word), 8'h08);
      chk("R9", "iters at limit", int'(out_iters), LIMIT);
      decode(8'h18 ^ 8'h04, "R3");
   endtask

   task automatic t_multi();
      decode(8'h03, "R3");
      decode(8'h81, "R5");
      chk("R5", "all-fail ok", int'(out_ok), 0);
      decode(8'hC3 ^ 8'h41, "R3");
   endtask

   task automatic t_backpressure();
      logic [7:0] w0; logic [3:0] i0;
      out_ready = 1'b0;
      send(8'h01);
      wait_out();
      w0 = out_word; i0 = out_iters;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R7", "held valid", int'(out_valid), 1);
         chk("R7", "held word", int'(out_word), int'(w0));
         chk("R7", "held iters", int'(out_iters), int'(i0));
         chk("R8", "closed input", int'(in_ready), 0);
      end
      judge(8'h01, "R7");
      out_ready = 1'b1;
      @(negedge clk);
      chk("R7", "released", int'(out_valid), 0);
   endtask

   task automatic t_busy();
      send(8'h08);
      in_valid = 1'b1; in_word = 8'h80;
      for (int k = 0; k < 4; k++) begin
         chk("R8", "in_ready busy", int'(in_ready), 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      wait_out();
      judge(8'h08, "R8");
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_single();
      t_twin();
      t_multi();
      t_backpressure();
      t_busy();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule